// File: doc/BRIEF.md
# Configurable Serial Audio Port

This block is the master side of a two-wire-plus-clock serial audio link. From the system clock it derives a bit clock through a fractional divider whose ratio is set by a numerator and a denominator. It also generates the frame sync. It then shifts one serial data line out and samples one serial data line in. Received bits are assembled into a left and a right parallel word. Transmit words are taken in at each frame start and serialised. The framing covers the usual formats. A two-channel frame with the sync marking the channel gives the I2S, left-justified and right-justified formats. A single-slot frame opened by a short sync pulse gives the PCM format.

Each direction has its own word width. The word is placed inside a 32-bit channel slot by a programmable bit offset. In MSB-justified placement the offset is counted from the start of the slot. In LSB-justified placement it is counted back from the end of the slot. One justification bit selects the placement, and it applies to both directions. An offset of 1 in MSB placement gives I2S. An offset of 0 in MSB placement gives left-justified. An offset of 0 in LSB placement gives right-justified. Configuration inputs are expected to be held steady while a frame is running. A new configuration is applied by resetting the block.

Top module: `serial_audio_port`

## Requirements
- R1: While reset is high and in the cycle after it is released, `bclk` is 1, `sync` is 0, `sd_out` is 0, `rx_valid` is 0 and both received words are zero.
- R2: With numerator N and denominator D, `bclk` toggles exactly floor(E*N/D) times over the first E system clock edges after reset. If N >= D, which includes D = 0, it toggles on every edge.
- R3: In two-channel mode (`cfg_mono`=0) a frame is 64 bit periods long. Each bit period starts at a `bclk` falling edge. `sync` is 0 for bit periods 0..31, which form the left slot, and 1 for bit periods 32..63, which form the right slot. `sync` changes only together with a falling `bclk` edge.
- R4: In single-slot mode (`cfg_mono`=1) a frame is 32 bit periods long. `sync` is 1 for the first `cfg_sync_w`+1 bit periods and 0 for the rest of the frame.
- R5: Width codes 0..7 select 8, 12, 16, 18, 20, 24, 28 and 32 bits.
- R6: Let W be the word width and P be `cfg_msb_pos`. With `cfg_lsb_just`=0 the MSB occupies slot bit P. With `cfg_lsb_just`=1 the MSB occupies slot bit 32-P-W, so the LSB sits P bits before the slot end. Word bits that would fall outside the slot are neither sent nor received.
- R7: `sd_out` changes only together with a falling `bclk` edge. Bit 31 of the transmit word is the MSB. Every slot bit outside the transmit word is driven 0. The transmit words are taken in at the first bit period of each frame.
- R8: `sd_in` is sampled at each rising `bclk` edge. The received word is left-aligned with bit 31 as the MSB and zeros below the LSB. `rx_valid` pulses for one cycle, in the cycle after the rising edge of the last bit of the frame. In that same cycle `rx_left` and `rx_right` carry the words of that frame, and `rx_right` is zero in single-slot mode.
- R9: The receive and transmit widths are set independently. Each direction uses only its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mono | input | 1 | 1 = single-slot framing, 0 = two-channel framing |
| cfg_sync_w | input | 3 | Sync pulse length minus one, single-slot mode |
| cfg_rx_w | input | 3 | Receive width code |
| cfg_tx_w | input | 3 | Transmit width code |
| cfg_msb_pos | input | SLOT_LOG2 | Word offset inside the slot |
| cfg_lsb_just | input | 1 | 0 = offset from slot start, 1 = offset from slot end |
| cfg_div_num | input | DIV_W | Bit clock divider numerator |
| cfg_div_den | input | DIV_W | Bit clock divider denominator |
| tx_left | input | DATA_W | Left or single-slot transmit word, MSB at top |
| tx_right | input | DATA_W | Right transmit word, MSB at top |
| sd_in | input | 1 | Serial receive data |
| bclk | output | 1 | Bit clock |
| sync | output | 1 | Frame sync |
| sd_out | output | 1 | Serial transmit data |
| rx_left | output | DATA_W | Received left or single-slot word |
| rx_right | output | DATA_W | Received right word |
| rx_valid | output | 1 | One-cycle pulse when a frame has been received |

## Verification
A slipped bit counter shows up first on `sync`. In the frame after the slip, `sync` moves one bit period early or late, and the serial data moves with it. A wrong offset or width decode corrupts `sd_out` at the first bit it touches, and it corrupts the received words when `rx_valid` next pulses, at most one frame later. A divider fault shows as a wrong number of `bclk` toggles within a few hundred cycles. A stale transmit buffer gives a wrong bit in the very next frame.

// File: rtl/saport_pkg.sv
package saport_pkg;

  typedef struct packed {
    logic       hit;
    logic [7:0] idx;
  } slot_hit_t;

  // R5: width code to word length, capped at the data path width
  function automatic int word_len(input logic [2:0] code, input int cap);
    int n;
    case (code)
      3'd0:    n = 8;
      3'd1:    n = 12;
      3'd2:    n = 16;
      3'd3:    n = 18;
      3'd4:    n = 20;
      3'd5:    n = 24;
      3'd6:    n = 28;
      default: n = 32;
    endcase
    return (n > cap) ? cap : n;
  endfunction

  // R6: which word bit (0 = MSB) a slot bit carries, if any
  function automatic slot_hit_t locate(input int slot_pos, input int slot_len,
                                       input int wlen, input int offs,
                                       input logic from_end);
    int first;
    int d;
    slot_hit_t r;
    first = from_end ? (slot_len - offs - wlen) : offs;
    d     = slot_pos - first;
    r.hit = (d >= 0) && (d < wlen);
    r.idx = r.hit ? 8'(d) : 8'd0;
    return r;
  endfunction

endpackage

// File: rtl/saport_clkgen.sv
module saport_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] num,
  input  logic [DIV_W-1:0] den,
  output logic             bclk,
  output logic             fall_now,
  output logic             rise_now
);
  logic [DIV_W:0] acc;
  logic [DIV_W:0] sum;
  logic [DIV_W:0] acc_nxt;
  logic           tog;

  always_comb begin
    sum = acc + {1'b0, num};
    if (num >= den) begin
      tog     = 1'b1;
      acc_nxt = '0;
    end else if (sum >= {1'b0, den}) begin
      tog     = 1'b1;
      acc_nxt = sum - {1'b0, den};
    end else begin
      tog     = 1'b0;
      acc_nxt = sum;
    end
  end

  assign fall_now = tog & bclk;
  assign rise_now = tog & ~bclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      bclk <= 1'b1;
    end else begin
      acc <= acc_nxt;
      if (tog) bclk <= ~bclk;
    end
  end
endmodule

// File: rtl/saport_framer.sv
module saport_framer #(
  parameter int SLOT_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 mono,
  input  logic [2:0]           sync_w,
  output logic [SLOT_LOG2:0]   cnt,
  output logic [SLOT_LOG2:0]   cnt_nxt,
  output logic                 is_last,
  output logic                 sync
);
  localparam int CW   = SLOT_LOG2 + 1;
  localparam int SLOT = 1 << SLOT_LOG2;

  logic [CW-1:0] last_idx;
  logic          sync_nxt;

  always_comb begin
    last_idx = mono ? CW'(SLOT - 1) : CW'(2 * SLOT - 1);
    cnt_nxt  = (cnt >= last_idx) ? '0 : cnt + CW'(1);
    is_last  = (cnt == last_idx);
    sync_nxt = mono ? (cnt_nxt <= CW'(sync_w)) : cnt_nxt[SLOT_LOG2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '1;
      sync <= 1'b0;
    end else if (step) begin
      cnt  <= cnt_nxt;
      sync <= sync_nxt;
    end
  end
endmodule

// File: rtl/saport_tx.sv
module saport_tx
  import saport_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SLOT_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic [SLOT_LOG2:0]   cnt_nxt,
  input  logic                 mono,
  input  logic [2:0]           w_code,
  input  logic [SLOT_LOG2-1:0] offs,
  input  logic                 from_end,
  input  logic [DATA_W-1:0]    word_l,
  input  logic [DATA_W-1:0]    word_r,
  output logic                 sd_out
);
  localparam int SLOT = 1 << SLOT_LOG2;

  logic [DATA_W-1:0] buf_l;
  logic [DATA_W-1:0] buf_r;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] shifted;
  logic              first;
  logic              right_ch;
  logic              bit_nxt;
  slot_hit_t         h;

  always_comb begin
    first    = (cnt_nxt == '0);
    right_ch = ~mono & cnt_nxt[SLOT_LOG2];
    word     = right_ch ? buf_r : (first ? word_l : buf_l);
    h        = locate(int'(cnt_nxt[SLOT_LOG2-1:0]), SLOT,
                      word_len(w_code, DATA_W), int'(offs), from_end);
    shifted  = word << h.idx;
    bit_nxt  = h.hit & shifted[DATA_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_l  <= '0;
      buf_r  <= '0;
      sd_out <= 1'b0;
    end else if (step) begin
      if (first) begin
        buf_l <= word_l;
        buf_r <= word_r;
      end
      sd_out <= bit_nxt;
    end
  end
endmodule

// File: rtl/saport_rx.sv
module saport_rx
  import saport_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SLOT_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic [SLOT_LOG2:0]   cnt,
  input  logic                 is_last,
  input  logic                 mono,
  input  logic [2:0]           w_code,
  input  logic [SLOT_LOG2-1:0] offs,
  input  logic                 from_end,
  input  logic                 sd_in,
  output logic [DATA_W-1:0]    rx_l,
  output logic [DATA_W-1:0]    rx_r,
  output logic                 rx_valid
);
  localparam int SLOT = 1 << SLOT_LOG2;
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] acc_l;
  logic [DATA_W-1:0] acc_r;
  logic [DATA_W-1:0] nxt_l;
  logic [DATA_W-1:0] nxt_r;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] set_v;
  logic              first;
  logic              right_ch;
  slot_hit_t         h;

  always_comb begin
    first    = (cnt == '0);
    right_ch = ~mono & cnt[SLOT_LOG2];
    h        = locate(int'(cnt[SLOT_LOG2-1:0]), SLOT,
                      word_len(w_code, DATA_W), int'(offs), from_end);
    mask     = h.hit ? (TOP_BIT >> h.idx) : '0;
    set_v    = sd_in ? mask : '0;
    nxt_l    = first ? '0 : acc_l;
    nxt_r    = first ? '0 : acc_r;
    if (right_ch) nxt_r = (nxt_r & ~mask) | set_v;
    else          nxt_l = (nxt_l & ~mask) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_l    <= '0;
      acc_r    <= '0;
      rx_l     <= '0;
      rx_r     <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (step) begin
        acc_l <= nxt_l;
        acc_r <= nxt_r;
        if (is_last) begin
          rx_l     <= nxt_l;
          rx_r     <= nxt_r;
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port #(
  parameter int DATA_W    = 32,
  parameter int SLOT_LOG2 = 5,
  parameter int DIV_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_mono,
  input  logic [2:0]           cfg_sync_w,
  input  logic [2:0]           cfg_rx_w,
  input  logic [2:0]           cfg_tx_w,
  input  logic [SLOT_LOG2-1:0] cfg_msb_pos,
  input  logic                 cfg_lsb_just,
  input  logic [DIV_W-1:0]     cfg_div_num,
  input  logic [DIV_W-1:0]     cfg_div_den,
  input  logic [DATA_W-1:0]    tx_left,
  input  logic [DATA_W-1:0]    tx_right,
  input  logic                 sd_in,
  output logic                 bclk,
  output logic                 sync,
  output logic                 sd_out,
  output logic [DATA_W-1:0]    rx_left,
  output logic [DATA_W-1:0]    rx_right,
  output logic                 rx_valid
);
  logic               fall_now;
  logic               rise_now;
  logic [SLOT_LOG2:0] cnt;
  logic [SLOT_LOG2:0] cnt_nxt;
  logic               is_last;

  saport_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .num(cfg_div_num), .den(cfg_div_den),
    .bclk(bclk), .fall_now(fall_now), .rise_now(rise_now)
  );

  saport_framer #(.SLOT_LOG2(SLOT_LOG2)) u_framer (
    .clk(clk), .rst(rst), .step(fall_now), .mono(cfg_mono),
    .sync_w(cfg_sync_w), .cnt(cnt), .cnt_nxt(cnt_nxt),
    .is_last(is_last), .sync(sync)
  );

  saport_tx #(.DATA_W(DATA_W), .SLOT_LOG2(SLOT_LOG2)) u_tx (
    .clk(clk), .rst(rst), .step(fall_now), .cnt_nxt(cnt_nxt),
    .mono(cfg_mono), .w_code(cfg_tx_w), .offs(cfg_msb_pos),
    .from_end(cfg_lsb_just), .word_l(tx_left), .word_r(tx_right),
    .sd_out(sd_out)
  );

  saport_rx #(.DATA_W(DATA_W), .SLOT_LOG2(SLOT_LOG2)) u_rx (
    .clk(clk), .rst(rst), .step(rise_now), .cnt(cnt), .is_last(is_last),
    .mono(cfg_mono), .w_code(cfg_rx_w), .offs(cfg_msb_pos),
    .from_end(cfg_lsb_just), .sd_in(sd_in),
    .rx_l(rx_left), .rx_r(rx_right), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/serial_audio_port_chk.sv
module serial_audio_port_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bclk,
  input logic              sync,
  input logic              sd_out,
  input logic              rx_valid,
  input logic              cfg_mono,
  input logic [DATA_W-1:0] rx_right
);
  // R7
  txd_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_out) |-> $fell(bclk));

  // R3
  sync_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sync) |-> $fell(bclk));

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8
  valid_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $rose(bclk));

  // R8
  mono_right_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_mono) |-> (rx_right == '0));
endmodule

bind serial_audio_port serial_audio_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bclk(bclk), .sync(sync), .sd_out(sd_out),
  .rx_valid(rx_valid), .cfg_mono(cfg_mono), .rx_right(rx_right)
);

// File: tb/serial_audio_port_bench.sv
module serial_audio_port_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        c_mono = 1'b0;
  logic [2:0]  c_sw = '0, c_rxw = '0, c_txw = '0;
  logic [4:0]  c_pos = '0;
  logic        c_lsb = 1'b0;
  logic [3:0]  c_num = 4'd1, c_den = 4'd1;
  logic [31:0] tx_left = '0, tx_right = '0;
  logic        sd_in = 1'b0;
  logic        bclk, sync, sd_out, rx_valid;
  logic [31:0] rx_left, rx_right;

  serial_audio_port u_serial_audio_port (
    .clk(clk), .rst(rst), .cfg_mono(c_mono), .cfg_sync_w(c_sw),
    .cfg_rx_w(c_rxw), .cfg_tx_w(c_txw), .cfg_msb_pos(c_pos),
    .cfg_lsb_just(c_lsb), .cfg_div_num(c_num), .cfg_div_den(c_den),
    .tx_left(tx_left), .tx_right(tx_right), .sd_in(sd_in),
    .bclk(bclk), .sync(sync), .sd_out(sd_out),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  int total = 0, bad = 0, frames = 0;
  bit active = 1'b0, done = 1'b0;
  logic [31:0] pend_l, pend_r, cur_l, cur_r;
  logic rxb [64];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int wl(input logic [2:0] code); // R5
    case (code)
      3'd0: return 8;   3'd1: return 12;  3'd2: return 16;  3'd3: return 18;
      3'd4: return 20;  3'd5: return 24;  3'd6: return 28;  default: return 32;
    endcase
  endfunction

  function automatic int flen();
    return c_mono ? 32 : 64;
  endfunction

  // word bit carried by frame bit idx, -1 if none (R6)
  function automatic int word_bit(input int idx, input int w);
    int s, st, d;
    s  = idx % 32;
    st = c_lsb ? (32 - int'(c_pos) - w) : int'(c_pos);
    d  = s - st;
    return (d >= 0 && d < w) ? d : -1;
  endfunction

  function automatic logic exp_tx(input int idx);
    int d;
    logic [31:0] wd;
    d  = word_bit(idx, wl(c_txw));
    wd = (!c_mono && idx >= 32) ? cur_r : cur_l;
    return (d < 0) ? 1'b0 : wd[31-d];
  endfunction

  task automatic agent();
    int idx = -1;
    logic pb = 1'b1;
    logic [31:0] el, er;
    forever begin
      @(negedge clk);
      if (!active) begin
        idx = -1; pb = 1'b1;
        continue;
      end
      if (pb && !bclk) begin
        idx = (idx < 0 || idx >= flen() - 1) ? 0 : idx + 1;
        if (idx == 0) begin
          cur_l = pend_l; cur_r = pend_r;
          foreach (rxb[i]) rxb[i] = 1'($urandom);
        end
        sd_in = rxb[idx];
      end else if (!pb && bclk) begin
        chk(sd_out === exp_tx(idx), "R5 R6 R7 R9 tx bit", longint'(sd_out), longint'(exp_tx(idx)));
        if (c_mono)
          chk(sync === (idx <= int'(c_sw)), "R4 mono sync", longint'(sync), longint'(idx <= int'(c_sw)));
        else
          chk(sync === (idx >= 32), "R3 stereo sync", longint'(sync), longint'(idx >= 32));
        if (idx == flen() - 1) begin
          el = '0; er = '0;
          for (int i = 0; i < flen(); i++) begin
            int d;
            d = word_bit(i, wl(c_rxw));
            if (d >= 0) begin
              if (!c_mono && i >= 32) er[31-d] = rxb[i];
              else                    el[31-d] = rxb[i];
            end
          end
          chk(rx_valid === 1'b1, "R8 valid at frame end", longint'(rx_valid), 1);
          chk(rx_left === el, "R5 R6 R8 R9 rx left", longint'(rx_left), longint'(el));
          chk(rx_right === er, "R6 R8 rx right", longint'(rx_right), longint'(er));
          frames++;
          pend_l = $urandom; pend_r = $urandom;
          tx_left = pend_l; tx_right = pend_r;
        end else if (rx_valid) begin
          chk(1'b0, "R8 stray valid", 1, 0);
        end
      end else if (rx_valid) begin
        chk(1'b0, "R8 valid off rise", 1, 0);
      end
      pb = bclk;
    end
  endtask

  task automatic run_phase(input logic mono, input logic [2:0] sw, input logic [2:0] rxw,
                           input logic [2:0] txw, input logic [4:0] pos, input logic lsb,
                           input int nf);
    active = 1'b0;
    rst = 1'b1;
    c_mono = mono; c_sw = sw; c_rxw = rxw; c_txw = txw; c_pos = pos; c_lsb = lsb;
    c_num = 4'd1; c_den = 4'd1;
    pend_l = $urandom; pend_r = $urandom;
    tx_left = pend_l; tx_right = pend_r;
    repeat (3) @(negedge clk);
    chk(bclk === 1'b1 && sync === 1'b0 && sd_out === 1'b0 && rx_valid === 1'b0 &&
        rx_left === '0 && rx_right === '0, "R1 reset state",
        longint'({bclk, sync, sd_out, rx_valid}), 64'h8);
    frames = 0;
    rst = 1'b0;
    active = 1'b1;
    while (frames < nf) @(negedge clk);
    active = 1'b0;
    @(negedge clk);
  endtask

  task automatic div_check(input int num, input int den);
    int tog = 0, expv;
    logic pb;
    active = 1'b0;
    rst = 1'b1;
    c_num = 4'(num); c_den = 4'(den);
    repeat (3) @(negedge clk);
    pb = bclk;
    rst = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (bclk !== pb) tog++;
      pb = bclk;
    end
    expv = (num >= den) ? 300 : (300 * num) / den;
    chk(tog == expv, "R2 bit clock toggles", tog, expv);
  endtask

  initial begin
    void'($urandom(32'd20240917));
    fork agent(); join_none
    div_check(1, 1);
    div_check(2, 3);
    div_check(1, 3);
    div_check(0, 0);
    div_check(5, 4);
    run_phase(1'b0, 3'd0, 3'd2, 3'd2, 5'd1,  1'b0, 3);
    run_phase(1'b0, 3'd0, 3'd5, 3'd7, 5'd0,  1'b0, 3);
    run_phase(1'b0, 3'd0, 3'd3, 3'd4, 5'd0,  1'b1, 3);
    run_phase(1'b0, 3'd0, 3'd0, 3'd6, 5'd3,  1'b1, 3);
    run_phase(1'b1, 3'd0, 3'd1, 3'd2, 5'd1,  1'b0, 3);
    run_phase(1'b1, 3'd7, 3'd7, 3'd0, 5'd0,  1'b1, 3);
    run_phase(1'b0, 3'd0, 3'd7, 3'd5, 5'd20, 1'b0, 3);
    run_phase(1'b0, 3'd0, 3'd7, 3'd7, 5'd31, 1'b1, 3);
    for (int r = 0; r < 8; r++)
      run_phase(1'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
                5'($urandom), 1'($urandom), 2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule